// File: doc/BRIEF.md
# Fully Associative Translation Lookup

This block is the search half of a 64-entry fully associative translation lookaside buffer. A requester presents a 64-bit virtual address together with the address-space identifier of the running context. Every stored entry compares itself against that pair in parallel. The block reports whether any entry matched and, if so, the index of the matching entry. The search is purely combinational, so the result is valid in the same cycle as the address.

Each entry holds six fields: a valid flag, a 2-bit region tag, a 27-bit even/odd page-pair number, a 16-bit page-size mask, an 8-bit identifier and a flag that marks the mapping as shared by all contexts. A registered write port replaces one whole entry per clock cycle at a chosen index. When more than one entry matches, the lowest-numbered one is reported. Address translation, fault signalling and refill are left to neighbouring logic, which uses the reported index.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (`hit`=0), including one whose other fields all equal the reset value of zero.
- R2: When `wr_en` is high at a rising clock edge, the entry at `wr_idx` is replaced by all six write fields, and the new contents decide lookups from the next cycle on. A later write to the same index overwrites the earlier one completely.
- R3: An entry whose valid flag is 0 never matches, whatever its other fields hold.
- R4: An entry matches only if its region tag equals virtual address bits 63..62.
- R5: The page-pair number taken from the address is bits 39..13. Address bits 61..40 and 12..0 take no part in the match.
- R6: For a set bit k of an entry's 16-bit page mask (k from 0 to 15), page-pair bit k is left out of the comparison. Page-pair bits 26..16 are always compared.
- R7: An entry matches only if its identifier equals `lk_asid`, unless its shared flag is 1. In that case the identifier is ignored.
- R8: When several entries match, `hit_idx` gives the lowest matching index, including index 63 when only the top entry matches.
- R9: On a miss `hit` is 0 and `hit_idx` is 0. On a hit `hit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the entry store |
| rst_n | input | 1 | Asynchronous active-low reset; clears every entry |
| wr_en | input | 1 | Write strobe for the entry store |
| wr_idx | input | 6 | Index of the entry to replace |
| wr_valid | input | 1 | Valid flag to store |
| wr_region | input | 2 | Region tag to store |
| wr_vpn2 | input | 27 | Page-pair number to store |
| wr_pmask | input | 16 | Page-size mask to store (set bit = page-pair bit ignored) |
| wr_asid | input | 8 | Address-space identifier to store |
| wr_gbl | input | 1 | Shared flag to store (1 = identifier ignored) |
| lk_vaddr | input | 64 | Virtual address to look up |
| lk_asid | input | 8 | Identifier of the current context |
| hit | output | 1 | At least one entry matches |
| hit_idx | output | 6 | Lowest matching index; 0 on a miss |

## Verification
Lookups are run against single entries that differ from the address in one field at a time: the region, a masked page-pair bit, an unmasked one, the identifier with and without the shared flag, and the valid flag. This shows that each of the four match terms is checked on its own. Pairs of overlapping entries at low and high indices, together with an invalidate of the lower one, separate lowest-index priority from plain any-hit reporting. Masks of 0, 0x00FF and 0xFFFF probe where the comparison boundary falls. A sweep with pseudo-random entries and addresses is also compared against a model in the bench.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    parameter int VA_W     = 64;
    parameter int REGION_W = 2;
    parameter int VPN_W    = 27;
    parameter int VPN_LSB  = 13;
    parameter int MASK_W   = 16;
    parameter int ASID_W   = 8;

    localparam int VPN_MSB    = VPN_LSB + VPN_W - 1;
    localparam int REGION_LSB = VA_W - REGION_W;

    typedef struct packed {
        logic                valid;
        logic [REGION_W-1:0] region;
        logic [VPN_W-1:0]    vpn2;
        logic [MASK_W-1:0]   pmask;
        logic [ASID_W-1:0]   asid;
        logic                gbl;
    } tlb_entry_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_entry,
    output tlb_entry_t [N-1:0]     entries
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entries[gi] <= '0;
                end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                    entries[gi] <= wr_entry;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
    import tlb_pkg::*;
(
    input  tlb_entry_t          entry,
    input  logic [REGION_W-1:0] req_region,
    input  logic [VPN_W-1:0]    req_vpn2,
    input  logic [ASID_W-1:0]   req_asid,
    output logic                match
);

    logic [VPN_W-1:0] cmp_mask;
    logic             region_ok;
    logic             vpn_ok;
    logic             asid_ok;

    always_comb begin
        cmp_mask  = ~{{(VPN_W-MASK_W){1'b0}}, entry.pmask};
        region_ok = (entry.region == req_region);
        vpn_ok    = (((entry.vpn2 ^ req_vpn2) & cmp_mask) == '0);
        asid_ok   = entry.gbl || (entry.asid == req_asid);
        match     = entry.valid && region_ok && vpn_ok && asid_ok;
    end

endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_valid,
    input  logic [REGION_W-1:0] wr_region,
    input  logic [VPN_W-1:0]    wr_vpn2,
    input  logic [MASK_W-1:0]   wr_pmask,
    input  logic [ASID_W-1:0]   wr_asid,
    input  logic                wr_gbl,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic [ASID_W-1:0]   lk_asid,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx
);

    tlb_entry_t          wr_entry;
    tlb_entry_t [N-1:0]  entries;
    logic [N-1:0]        match_vec;
    logic [REGION_W-1:0] req_region;
    logic [VPN_W-1:0]    req_vpn2;

    always_comb begin
        wr_entry.valid  = wr_valid;
        wr_entry.region = wr_region;
        wr_entry.vpn2   = wr_vpn2;
        wr_entry.pmask  = wr_pmask;
        wr_entry.asid   = wr_asid;
        wr_entry.gbl    = wr_gbl;
        req_region      = lk_vaddr[VA_W-1:REGION_LSB];
        req_vpn2        = lk_vaddr[VPN_MSB:VPN_LSB];
    end

    tlb_entry_store #(.N(N), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .entries  (entries)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_cmp
            tlb_match_cell cell_i (
                .entry      (entries[gi]),
                .req_region (req_region),
                .req_vpn2   (req_vpn2),
                .req_asid   (lk_asid),
                .match      (match_vec[gi])
            );
        end
    endgenerate

    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) enc_i (
        .req (match_vec),
        .any (hit),
        .idx (hit_idx)
    );

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk
    import tlb_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic               wr_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_idx,
    input tlb_entry_t [N-1:0] entries,
    input logic [N-1:0]       match_vec
);

    logic [N-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) < hit_idx) below_mask[i] = 1'b1;
        end
    end

    AST_MISS_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0)); // R9

    AST_HIT_HAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[hit_idx]); // R9

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & below_mask) == '0)); // R8

    AST_HIT_ENTRY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> entries[hit_idx].valid); // R3

    AST_HIT_REGION_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (entries[hit_idx].region == lk_vaddr[VA_W-1:REGION_LSB])); // R4

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entries[$past(wr_idx)].valid == $past(wr_valid))); // R2

    AST_RESULT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lk_vaddr) |-> !$isunknown({hit, hit_idx})); // R9

endmodule

bind tlb_lookup tlb_lookup_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .lk_vaddr  (lk_vaddr),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .entries   (entries),
    .match_vec (match_vec)
);

// File: tb/tlb_lookup_tb_top.sv
`timescale 1ns/1ps
module tlb_lookup_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [1:0]  wr_region = '0;
    logic [26:0] wr_vpn2 = '0;
    logic [15:0] wr_pmask = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_gbl = 1'b0;
    logic [63:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0;
    logic        hit;
    logic [5:0]  hit_idx;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model of the entry array
    logic        m_valid  [64];
    logic [1:0]  m_region [64];
    logic [26:0] m_vpn2   [64];
    logic [15:0] m_pmask  [64];
    logic [7:0]  m_asid   [64];
    logic        m_gbl    [64];

    always #5 clk = ~clk;

    tlb_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_region(wr_region), .wr_vpn2(wr_vpn2),
        .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_gbl(wr_gbl),
        .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .hit(hit), .hit_idx(hit_idx)
    );

    function automatic logic [63:0] mk_va(input logic [1:0] rg, input logic [26:0] vpn,
                                          input logic [21:0] mid, input logic [12:0] low);
        return {rg, mid, vpn, low};
    endfunction

    function automatic void ref_lookup(input logic [63:0] va, input logic [7:0] asid,
                                       output logic h, output logic [5:0] ix);
        h = 1'b0;
        ix = '0;
        for (int i = 0; i < 64; i++) begin
            logic [26:0] msk;
            msk = ~{11'b0, m_pmask[i]};
            if (!h && m_valid[i] && (m_region[i] == va[63:62]) &&
                (((m_vpn2[i] ^ va[39:13]) & msk) == '0) &&
                (m_gbl[i] || (m_asid[i] == asid))) begin
                h = 1'b1;
                ix = 6'(i);
            end
        end
    endfunction

    task automatic write_entry(input int idx, input logic v, input logic [1:0] rg,
                               input logic [26:0] vpn, input logic [15:0] pm,
                               input logic [7:0] asid, input logic g);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 6'(idx); wr_valid = v; wr_region = rg;
        wr_vpn2 = vpn; wr_pmask = pm; wr_asid = asid; wr_gbl = g;
        @(negedge clk);
        wr_en = 1'b0;
        m_valid[idx] = v; m_region[idx] = rg; m_vpn2[idx] = vpn;
        m_pmask[idx] = pm; m_asid[idx] = asid; m_gbl[idx] = g;
    endtask

    task automatic check_lookup(input string req, input logic [63:0] va, input logic [7:0] asid,
                                input logic exp_hit, input logic [5:0] exp_idx);
        lk_vaddr = va;
        lk_asid  = asid;
        #1;
        n_checks++;
        if (hit !== exp_hit || hit_idx !== exp_idx) begin
            n_fails++;
            $display("FAIL %s: va=%h asid=%h actual hit=%b idx=%0d expected hit=%b idx=%0d",
                     req, va, asid, hit, hit_idx, exp_hit, exp_idx);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 64; i++) write_entry(i, 1'b0, 2'b00, '0, '0, '0, 1'b0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 64; i++) begin
            m_valid[i] = 0; m_region[i] = 0; m_vpn2[i] = 0;
            m_pmask[i] = 0; m_asid[i] = 0; m_gbl[i] = 0;
        end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_lookup("R1", 64'h0, 8'h00, 1'b0, 6'd0);
        check_lookup("R1", mk_va(2'b11, 27'h7FFFFFF, 22'h0, 13'h0), 8'hFF, 1'b0, 6'd0);
    endtask

    task automatic t_basic();
        write_entry(7, 1'b1, 2'b01, 27'h0123456, 16'h0000, 8'h42, 1'b0);
        check_lookup("R2", mk_va(2'b01, 27'h0123456, 22'h0, 13'h0), 8'h42, 1'b1, 6'd7);
        // unused address bits vary
        check_lookup("R5", mk_va(2'b01, 27'h0123456, 22'h3FFFFF, 13'h1FFF), 8'h42, 1'b1, 6'd7);
        check_lookup("R5", mk_va(2'b01, 27'h0123457, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
        check_lookup("R4", mk_va(2'b00, 27'h0123456, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
        check_lookup("R4", mk_va(2'b11, 27'h0123456, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
        check_lookup("R9", mk_va(2'b01, 27'h0000000, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
        // overwrite same index
        write_entry(7, 1'b1, 2'b10, 27'h0000ABC, 16'h0000, 8'h42, 1'b0);
        check_lookup("R2", mk_va(2'b01, 27'h0123456, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
        check_lookup("R2", mk_va(2'b10, 27'h0000ABC, 22'h0, 13'h0), 8'h42, 1'b1, 6'd7);
        write_entry(7, 1'b0, 2'b10, 27'h0000ABC, 16'h0000, 8'h42, 1'b0);
        check_lookup("R3", mk_va(2'b10, 27'h0000ABC, 22'h0, 13'h0), 8'h42, 1'b0, 6'd0);
    endtask

    task automatic t_mask();
        write_entry(5, 1'b1, 2'b00, 27'h0ABCD00, 16'h00FF, 8'h01, 1'b0);
        check_lookup("R6", mk_va(2'b00, 27'h0ABCDFF, 22'h0, 13'h0), 8'h01, 1'b1, 6'd5);
        check_lookup("R6", mk_va(2'b00, 27'h0ABCC00, 22'h0, 13'h0), 8'h01, 1'b0, 6'd0);
        write_entry(5, 1'b1, 2'b00, 27'h1230000, 16'hFFFF, 8'h01, 1'b0);
        check_lookup("R6", mk_va(2'b00, 27'h123FFFF, 22'h0, 13'h0), 8'h01, 1'b1, 6'd5);
        check_lookup("R6", mk_va(2'b00, 27'h1210000, 22'h0, 13'h0), 8'h01, 1'b0, 6'd0);
        check_lookup("R6", mk_va(2'b00, 27'h5230000, 22'h0, 13'h0), 8'h01, 1'b0, 6'd0);
        write_entry(5, 1'b0, 2'b00, '0, '0, '0, 1'b0);
    endtask

    task automatic t_asid();
        write_entry(20, 1'b1, 2'b00, 27'h0000100, 16'h0000, 8'h33, 1'b0);
        check_lookup("R7", mk_va(2'b00, 27'h0000100, 22'h0, 13'h0), 8'h33, 1'b1, 6'd20);
        check_lookup("R7", mk_va(2'b00, 27'h0000100, 22'h0, 13'h0), 8'h34, 1'b0, 6'd0);
        write_entry(20, 1'b1, 2'b00, 27'h0000100, 16'h0000, 8'h33, 1'b1);
        check_lookup("R7", mk_va(2'b00, 27'h0000100, 22'h0, 13'h0), 8'hC4, 1'b1, 6'd20);
        write_entry(20, 1'b0, 2'b00, '0, '0, '0, 1'b0);
    endtask

    task automatic t_priority();
        write_entry(10, 1'b1, 2'b11, 27'h0005550, 16'h000F, 8'h09, 1'b0);
        write_entry(3,  1'b1, 2'b11, 27'h0005555, 16'h0000, 8'h00, 1'b1);
        write_entry(63, 1'b1, 2'b11, 27'h0005555, 16'h0000, 8'h09, 1'b0);
        check_lookup("R8", mk_va(2'b11, 27'h0005555, 22'h0, 13'h0), 8'h09, 1'b1, 6'd3);
        write_entry(3, 1'b0, 2'b11, 27'h0005555, 16'h0000, 8'h00, 1'b1);
        check_lookup("R8", mk_va(2'b11, 27'h0005555, 22'h0, 13'h0), 8'h09, 1'b1, 6'd10);
        write_entry(10, 1'b0, 2'b11, 27'h0005550, 16'h000F, 8'h09, 1'b0);
        check_lookup("R8", mk_va(2'b11, 27'h0005555, 22'h0, 13'h0), 8'h09, 1'b1, 6'd63);
        write_entry(63, 1'b0, 2'b11, '0, '0, '0, 1'b0);
        check_lookup("R9", mk_va(2'b11, 27'h0005555, 22'h0, 13'h0), 8'h09, 1'b0, 6'd0);
    endtask

    task automatic t_sweep();
        logic [31:0] lf = 32'hACE1_2345;
        logic        eh;
        logic [5:0]  ei;
        logic [15:0] pm;
        for (int i = 0; i < 64; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            case (lf[9:8])
                2'd0: pm = 16'h0000;
                2'd1: pm = 16'h0003;
                2'd2: pm = 16'h000F;
                default: pm = 16'h003F;
            endcase
            write_entry(i, lf[10], {1'b0, lf[11]}, {19'h0, lf[7:0]}, pm, {6'h0, lf[13:12]}, lf[14]);
        end
        for (int k = 0; k < 300; k++) begin
            logic [63:0] va;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            va = mk_va({1'b0, lf[8]}, {19'h0, lf[7:0]}, lf[30:9], lf[12:0]);
            ref_lookup(va, {6'h0, lf[14:13]}, eh, ei);
            check_lookup("R8 sweep", va, {6'h0, lf[14:13]}, eh, ei);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_asid();
        t_priority();
        t_sweep();
        clear_all();
        check_lookup("R3", 64'h0, 8'h00, 1'b0, 6'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule